// File: doc/BRIEF.md
# Load/Store Multiple Sequencer

This block is a micro-sequencer inside a 32-bit processor core. It carries out one load-multiple or store-multiple operation at a time. A start strobe captures four inputs: a 16-bit register-selection mask, a base address, an addressing direction and a load/store select. It then performs one word access to memory for each selected register. Each access waits on a request/ready handshake before the next one begins.

On a load, each word that returns goes to the register file through a write port, except for register 15. Register 15 is the program counter, so a word loaded into it becomes a branch target instead. On a store, the block reads each register through a read port and places the value on the memory write data. When the operation ends, the block can present a new base value. The core writes that value back to the base register when writeback was requested. Two cases raise a usage fault: an empty selection mask, and a program-counter word whose low bit is clear.

Top module: `ldst_multi_seq`

## Requirements
- R1: After a synchronous active-low reset the outputs `mem_req`, `done`, `fault`, `busy`, `base_we`, `branch_valid` and `rf_we` are all 0.
- R2: With `dec_before`=0 (ascending mode), the k-th access (k from 0) uses address base + 4*k. Registers are visited from the lowest set mask bit to the highest.
- R3: With `dec_before`=1 (descending mode), the k-th access uses address base - 4*n + 4*k, where n is the number of set mask bits. The lowest-numbered register still receives the lowest address.
- R4: Bits [1:0] of `mem_addr` are always 0 while `mem_req` is 1, even when the base has nonzero low bits.
- R5: `mem_req` stays asserted with a stable address until `mem_ready` is 1. Exactly n accesses complete per operation, and consecutive addresses differ by 4.
- R6: On a load, a handshake cycle for register i < 15 asserts `rf_we`, with `rf_waddr`=i and `rf_wdata`=`mem_rdata`. Register 15 is never written through `rf_we`.
- R7: On a store, the handshake cycle has `mem_we`=1, `rf_raddr` equal to the register being stored, and `mem_wdata` equal to that register's value.
- R8: `done` is 1 for exactly one cycle, in the cycle after the last handshake. In that cycle `base_we` equals the writeback flag, and `base_wdata` is base + 4*n in ascending mode or base - 4*n in descending mode.
- R9: A load that includes register 15 and returns a word with bit 0 = 1 asserts `branch_valid` together with `done`. `branch_target` is that word with bit 0 cleared.
- R10: A load that returns a word with bit 0 = 0 for register 15 asserts `fault` for one cycle in place of `done`, with no writeback and no branch.
- R11: A start with an empty mask asserts `fault` in the next cycle and performs no memory access.
- R12: `start` is ignored while `busy` is 1. A second start during an operation changes neither its addresses nor its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| is_load | input | 1 | 1 = load from memory, 0 = store to memory |
| dec_before | input | 1 | 1 = descending mode, 0 = ascending mode |
| wback | input | 1 | Request base writeback at the end |
| base_addr | input | 32 | Base address |
| reg_list | input | 16 | Register selection mask, bit i = register i |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts or completes the access |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| base_we | output | 1 | Write updated base back |
| base_wdata | output | 32 | Updated base value |
| branch_valid | output | 1 | Loaded program counter: take branch |
| branch_target | output | 32 | Halfword-aligned branch address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished normally |
| fault | output | 1 | Usage fault |

## Verification
A corrupted pending mask or address register shows up on the very next handshake. The visible effect is a wrong `mem_addr`, a wrong register index, or one access too many or too few. It is caught either at that handshake or at the `done` cycle that follows the last access. A wrong state encoding shows in the cycle after the last handshake: `done` and `fault` appear swapped, or the writeback and branch outputs appear in the wrong cycle. Random masks with random ready delays reach every register position in both directions. Directed cases cover the empty mask, the full mask, the good and bad program-counter words, and a start that arrives while busy.

// File: rtl/ldst_multi_pkg.sv
// Shared types for the load/store multiple sequencer.
// Assumes nothing beyond a single clock domain.
package ldst_multi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2,
        ST_FLT  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ldst_multi_pick.sv
// Finds the lowest set bit of the pending mask.
// Gives its index, a one-hot mask of it, and whether it is the only bit left.
// Assumes the caller ignores the outputs when the mask is zero.
module ldst_multi_pick #(
    parameter int NREG = 16,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [NREG-1:0] pend,
    output logic [IDXW-1:0] idx,
    output logic [NREG-1:0] onehot,
    output logic            last
);
    // Priority scan: a lower index overrides a higher one.
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDXW'(i);
        end
    end

    // Isolate the lowest set bit, then test whether any other bit is set.
    assign onehot = pend & (~pend + NREG'(1));
    assign last   = ((pend & ~onehot) == '0);
endmodule

// File: rtl/ldst_multi_addr.sv
// Computes the first access address and the final base value.
// Uses the population count of the register mask.
// Assumes arithmetic wraps modulo 2**AW.
module ldst_multi_addr #(
    parameter int NREG = 16,
    parameter int AW   = 32
) (
    input  logic [NREG-1:0] mask,
    input  logic [AW-1:0]   base,
    input  logic            dec,
    output logic [AW-1:0]   first_addr,
    output logic [AW-1:0]   final_base,
    output logic            empty
);
    localparam int CW = $clog2(NREG + 1);

    logic [CW-1:0] count;
    logic [AW-1:0] span;

    // Count selected registers.
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) count = count + CW'(mask[i]);
    end

    // Byte span of the whole transfer, and the two end points.
    assign span       = AW'(count) << 2;
    assign empty      = (count == '0);
    assign first_addr = dec ? (base - span) : base;
    assign final_base = dec ? (base - span) : (base + span);
endmodule

// File: rtl/ldst_multi_seq.sv
// Load/store multiple sequencer.
// Issues one word access per selected register, lowest register at the lowest
// address, in ascending or descending mode, and optionally writes the base back.
// A loaded program-counter word (top register) becomes a branch target.
// Assumes the register file read is combinational and the memory holds data
// stable while ready is high.
module ldst_multi_seq #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            is_load,
    input  logic            dec_before,
    input  logic            wback,
    input  logic [AW-1:0]   base_addr,
    input  logic [NREG-1:0] reg_list,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ready,
    input  logic [DW-1:0]   mem_rdata,
    output logic [IDXW-1:0] rf_raddr,
    input  logic [DW-1:0]   rf_rdata,
    output logic            rf_we,
    output logic [IDXW-1:0] rf_waddr,
    output logic [DW-1:0]   rf_wdata,
    output logic            base_we,
    output logic [AW-1:0]   base_wdata,
    output logic            branch_valid,
    output logic [DW-1:0]   branch_target,
    output logic            busy,
    output logic            done,
    output logic            fault
);
    import ldst_multi_pkg::*;

    localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

    seq_state_t      st_q;
    logic [NREG-1:0] pend_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   wb_q;
    logic            load_q;
    logic            wback_q;
    logic            br_q;
    logic [DW-1:0]   tgt_q;

    logic [IDXW-1:0] cur_idx;
    logic [NREG-1:0] cur_bit;
    logic            cur_last;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic            list_empty;
    logic            hs;
    logic            pc_hit;

    ldst_multi_pick #(.NREG(NREG)) u_pick (
        .pend   (pend_q),
        .idx    (cur_idx),
        .onehot (cur_bit),
        .last   (cur_last)
    );

    ldst_multi_addr #(.NREG(NREG), .AW(AW)) u_addr (
        .mask       (reg_list),
        .base       (base_addr),
        .dec        (dec_before),
        .first_addr (first_addr),
        .final_base (final_base),
        .empty      (list_empty)
    );

    // Handshake and program-counter detection for the current access.
    assign hs     = (st_q == ST_XFER) && mem_ready;
    assign pc_hit = hs && load_q && (cur_idx == PC_IDX);

    // Sequencer state, pending mask, address and end-of-operation results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            wb_q    <= '0;
            load_q  <= 1'b0;
            wback_q <= 1'b0;
            br_q    <= 1'b0;
            tgt_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        pend_q  <= reg_list;
                        addr_q  <= first_addr;
                        wb_q    <= final_base;
                        load_q  <= is_load;
                        wback_q <= wback;
                        br_q    <= 1'b0;
                        st_q    <= list_empty ? ST_FLT : ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (hs) begin
                        pend_q <= pend_q & ~cur_bit;
                        addr_q <= addr_q + AW'(4);
                        if (pc_hit) begin
                            br_q  <= 1'b1;
                            tgt_q <= mem_rdata & ~DW'(1);
                        end
                        if (pc_hit && !mem_rdata[0]) st_q <= ST_FLT;
                        else if (cur_last)          st_q <= ST_FIN;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Memory side of the current access.
    assign mem_req   = (st_q == ST_XFER);
    assign mem_we    = !load_q;
    assign mem_addr  = {addr_q[AW-1:2], 2'b00};
    assign mem_wdata = rf_rdata;

    // Register file side of the current access.
    assign rf_raddr = cur_idx;
    assign rf_we    = hs && load_q && (cur_idx != PC_IDX);
    assign rf_waddr = cur_idx;
    assign rf_wdata = mem_rdata;

    // End-of-operation outputs.
    assign done          = (st_q == ST_FIN);
    assign fault         = (st_q == ST_FLT);
    assign busy          = (st_q != ST_IDLE);
    assign base_we       = done && wback_q;
    assign base_wdata    = wb_q;
    assign branch_valid  = done && br_q;
    assign branch_target = tgt_q;
endmodule

// File: rtl/ldst_multi_chk.sv
// Port-level checker for the load/store multiple sequencer, bound to the top.
module ldst_multi_chk #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int DW   = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_we,
    input logic [AW-1:0]   mem_addr,
    input logic            mem_ready,
    input logic            rf_we,
    input logic [IDXW-1:0] rf_waddr,
    input logic            base_we,
    input logic            branch_valid,
    input logic [DW-1:0]   branch_target,
    input logic            done,
    input logic            fault
);
    a_r4_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

    a_r6_no_pc_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != IDXW'(NREG - 1) && mem_req && mem_ready && !mem_we));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |-> done);

    a_r9_branch: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> (done && !branch_target[0]));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    a_r11_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_req && !base_we && !branch_valid));
endmodule

bind ldst_multi_seq ldst_multi_chk #(.NREG(NREG), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/ldst_multi_seq_bench.sv
module ldst_multi_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, is_load = 1'b0, dec_before = 1'b0, wback = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_list = '0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata, base_wdata, branch_target;
    logic        rf_we, base_we, branch_valid, busy, done, fault;

    logic [31:0] regs [16];
    logic [31:0] mem  [64];
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];

    ldst_multi_seq u_ldst_multi_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load),
        .dec_before(dec_before), .wback(wback), .base_addr(base_addr),
        .reg_list(reg_list), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .base_we(base_we), .base_wdata(base_wdata),
        .branch_valid(branch_valid), .branch_target(branch_target),
        .busy(busy), .done(done), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    // Run one operation; pc_ok sets bit 0 of the program-counter word, poke
    // issues a second start while busy.
    task automatic run_op(input logic [15:0] lst, input logic [31:0] base,
                          input logic ld, input logic dc, input logic wb,
                          input logic pc_ok, input logic poke);
        int n, k, guard;
        logic [3:0]  ex_idx [16];
        logic [31:0] start_a, exp_a, pcw, a;
        bit fin, pc_bad;
        n = popc(lst);
        k = 0;
        for (int i = 0; i < 16; i++) if (lst[i]) begin ex_idx[k] = 4'(i); k++; end
        k = 0;
        start_a = dc ? base - 32'(4 * n) : base;
        pcw = '0;
        pc_bad = 1'b0;
        if (ld && lst[15]) begin
            a = start_a + 32'(4 * (n - 1));
            mem[a[7:2]] = {mem[a[7:2]][31:1], pc_ok};
            pcw = mem[a[7:2]];
            pc_bad = !pc_ok;
        end
        @(negedge clk);
        reg_list = lst; base_addr = base; is_load = ld; dec_before = dc;
        wback = wb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n != 0) chk(busy == 1'b1, "R12 busy", 32'(busy), 32'd1);
        if (poke) begin
            start = 1'b1; reg_list = 16'h0001; base_addr = base + 32'd64;
            dec_before = ~dc; is_load = ~ld;
        end
        guard = 0;
        fin = 1'b0;
        while (!fin) begin
            if (done || fault) fin = 1'b1;
            else begin
                if (mem_req) begin
                    mem_ready = (($urandom % 3) != 0);
                    mem_rdata = mem[mem_addr[7:2]];
                end else mem_ready = 1'b0;
                #1;
                if (mem_req && mem_ready) begin
                    exp_a = (start_a + 32'(4 * k)) & ~32'd3;
                    if (k >= n) chk(1'b0, "R5 extra access", 32'(k), 32'(n));
                    else begin
                        chk(mem_addr == exp_a, dc ? "R3 addr" : "R2 addr", mem_addr, exp_a);
                        chk(mem_addr[1:0] == 2'b00, "R4 align", mem_addr, exp_a);
                        if (ld) begin
                            if (ex_idx[k] != 4'd15)
                                chk(rf_we && rf_waddr == ex_idx[k] && rf_wdata == mem_rdata,
                                    "R6 rf write", {rf_we, 23'd0, rf_waddr, rf_wdata[3:0]},
                                    {1'b1, 23'd0, ex_idx[k], mem_rdata[3:0]});
                            else chk(!rf_we, "R6 pc not written", 32'(rf_we), 32'd0);
                        end else begin
                            chk(mem_we && rf_raddr == ex_idx[k], "R7 store idx",
                                {mem_we, 27'd0, rf_raddr}, {1'b1, 27'd0, ex_idx[k]});
                            chk(mem_wdata == regs[ex_idx[k]], "R7 store data",
                                mem_wdata, regs[ex_idx[k]]);
                            mem[mem_addr[7:2]] = mem_wdata;
                        end
                    end
                    k++;
                end
                @(negedge clk);
                start = 1'b0;
                guard++;
                if (guard > 400) begin
                    chk(1'b0, "R5 operation hung", 32'(k), 32'(n));
                    fin = 1'b1;
                end
            end
        end
        mem_ready = 1'b0;
        chk(k == n, "R5 access count", 32'(k), 32'(n));
        if (n == 0) begin
            chk(fault && !done, "R11 empty fault", {fault, done}, 32'd2);
        end else if (pc_bad) begin
            chk(fault && !done && !base_we && !branch_valid, "R10 bad pc fault",
                {fault, done, base_we, branch_valid}, 32'd8);
        end else begin
            chk(done && !fault, "R8 done", {done, fault}, 32'd2);
            chk(base_we == wb, "R8 base_we", 32'(base_we), 32'(wb));
            if (wb) begin
                exp_a = dc ? base - 32'(4 * n) : base + 32'(4 * n);
                chk(base_wdata == exp_a, "R8 base value", base_wdata, exp_a);
            end
            chk(branch_valid == (ld && lst[15]), "R9 branch_valid",
                32'(branch_valid), 32'(ld && lst[15]));
            if (ld && lst[15])
                chk(branch_target == (pcw & ~32'd1), "R9 target", branch_target, pcw & ~32'd1);
        end
        @(negedge clk);
        chk(!done && !fault && !mem_req, "R8 single pulse", {done, fault, mem_req}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) regs[i] = $urandom;
        for (int i = 0; i < 64; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        chk(!mem_req && !done && !fault && !busy && !base_we && !branch_valid && !rf_we,
            "R1 reset state",
            {mem_req, done, fault, busy, base_we, branch_valid, rf_we}, 32'd0);
        rst_n = 1'b1;
        // Directed corners
        run_op(16'h0000, 32'd100, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);   // R11
        run_op(16'hFFFF, 32'd64,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0);   // R2 full store
        run_op(16'h0100, 32'd130, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);   // R3, R4 odd base
        run_op(16'h8005, 32'd96,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0);   // R9
        run_op(16'h8012, 32'd160, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);   // R10
        run_op(16'h0C30, 32'd80,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1);   // R12
        // Constrained random
        for (int t = 0; t < 60; t++) begin
            logic [15:0] l;
            l = 16'($urandom);
            if (($urandom % 8) == 0) l = 16'h0001 << ($urandom % 16);
            run_op(l, 32'd64 + 32'($urandom % 128), 1'($urandom), 1'($urandom),
                   1'($urandom), 1'(($urandom % 4) != 0), 1'(($urandom % 5) == 0));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule